// File: doc/BRIEF.md
# Instrument Status Reporting Unit

This block keeps the status registers of a remotely controlled measurement instrument and decides when the instrument asks its controller for service. Event pulses from the rest of the instrument are latched into an event register. An event enable mask selects which latched events count towards an event summary. The status byte gathers that summary with a message-available flag from the output queue and with the summary flags of the questionable and operation status groups.

A service request enable register selects which status byte bits may raise the master summary bit. A rising master summary raises the service request output. A serial poll reads the request-service value and withdraws the request until a fresh rising condition appears. The event register is cleared by a read-and-clear strobe or by clear-status. The service request enable register survives clear-status and is cleared only by power-on reset or device clear. Power-on leaves the power-on event bit set.

Top module: `status_report_unit`

## Requirements
- R1: After power-on reset (rst_n low at a clock edge) the event register reads 0x80 (only bit 7, the power-on bit, set), the event enable mask and service request enable register are 0, and srq_o is low.
- R2: A 1 on bit i of evt_pulse_i sets bit i of esr_o from the next clock edge on, and the bit stays set after the pulse has gone.
- R3: esr_rd_i or cls_i clears esr_o at the next clock edge. An event bit pulsed in the same cycle as the clear is set after it.
- R4: Status byte bit 5 is 1 exactly when some bit is 1 in both esr_o and the event enable mask (written with ese_wr_i/ese_wdata_i). clear-status leaves the mask unchanged.
- R5: Status byte bit 4 follows oq_nonempty_i, bit 3 follows ques_sum_i, bit 7 follows oper_sum_i, and bits 2..0 read 0, all without a clock delay.
- R6: Status byte bit 6 (master summary) is 1 exactly when some status byte bit other than 6 is 1 together with the same bit of the service request enable register. Enable bit 6 has no effect.
- R7: sre_wr_i loads sre_wdata_i into the service request enable register. dev_clr_i clears it and wins over a write in the same cycle. cls_i leaves it unchanged.
- R8: srq_o goes high at the clock edge after the master summary rises and goes low at the clock edge after the master summary is 0.
- R9: poll_byte_o equals the status byte with bit 6 replaced by srq_o. poll_i clears srq_o at the next edge, and it stays low while the master summary stays 1. A master summary rise in the same cycle as poll_i keeps srq_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| dev_clr_i | input | 1 | Device-clear strobe |
| cls_i | input | 1 | Clear-status strobe |
| evt_pulse_i | input | 8 | Event pulses, one per event register bit |
| oq_nonempty_i | input | 1 | Output queue holds data |
| ques_sum_i | input | 1 | Questionable group has an enabled true bit |
| oper_sum_i | input | 1 | Operation group has an enabled true bit |
| sre_wr_i | input | 1 | Write strobe for service request enable register |
| sre_wdata_i | input | 8 | Write data for service request enable register |
| ese_wr_i | input | 1 | Write strobe for event enable mask |
| ese_wdata_i | input | 8 | Write data for event enable mask |
| esr_rd_i | input | 1 | Read-and-clear strobe for the event register |
| esr_o | output | 8 | Event register contents |
| stb_o | output | 8 | Status byte with master summary in bit 6 |
| poll_i | input | 1 | Serial-poll read strobe |
| poll_byte_o | output | 8 | Serial-poll byte, request-service value in bit 6 |
| srq_o | output | 1 | Service request |

## Verification
The bench pulses an event in the same cycle as a read-and-clear. A design that lets the clear win loses that event. The bench sets enable bit 6 alone with every summary active; a design that fails to ignore it reports a service request that nothing asked for. It issues a device clear together with an enable write, and issues clear-status with an active request. A wrong priority leaves the enable set, and a clear-status that touches the enable drops the master summary. The poll sequence repeats a poll, re-arms the request by dropping and raising the summary, and finally raises the summary in the same cycle as a poll. A request flag that is not edge-based either re-asserts at once or never comes back.

// File: rtl/stat_pkg.sv
// Package: shared widths, bit positions and reset values of the status unit.
// Assumes an 8-bit status byte and an 8-bit event register.
package stat_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned PON_BIT  = 7;   // power-on bit of the event register
    localparam int unsigned OPER_BIT = 7;   // status byte: operation summary
    localparam int unsigned MSS_BIT  = 6;   // status byte: master summary / request
    localparam int unsigned ESB_BIT  = 5;   // status byte: event summary
    localparam int unsigned MAV_BIT  = 4;   // status byte: message available
    localparam int unsigned QUES_BIT = 3;   // status byte: questionable summary
    localparam logic [REG_W-1:0] ESR_RST = REG_W'(1) << PON_BIT;
endpackage

// File: rtl/evt_latch.sv
// Module: event register with enable mask and event summary.
// Holds sticky event bits, clears them on read or clear-status (events in the
// same cycle survive the clear), and reports whether any enabled bit is set.
// Assumes strobes are single-cycle and synchronous to clk.
module evt_latch
    import stat_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_pulse_i,
    input  logic         clr_i,
    input  logic         mask_wr_i,
    input  logic [W-1:0] mask_wdata_i,
    output logic [W-1:0] esr_o,
    output logic         sum_o
);
    localparam logic [W-1:0] RST_VAL = W'(ESR_RST);

    logic [W-1:0] esr_q;
    logic [W-1:0] mask_q;

    // Event bits: power-on value, clear on request, new events always merged in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esr_q <= RST_VAL;
        end else begin
            esr_q <= (clr_i ? '0 : esr_q) | evt_pulse_i;
        end
    end

    // Enable mask: reset at power-on, loaded on write, untouched otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    // Summary of enabled latched events.
    always_comb begin
        sum_o = |(esr_q & mask_q);
    end

    assign esr_o = esr_q;

    // R2
    evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse_i != '0) |=> ((esr_q & $past(evt_pulse_i)) == $past(evt_pulse_i)));

    // R2
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((esr_q & $past(esr_q)) == $past(esr_q)));

    // R3
    clr_only_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((esr_q & ~$past(evt_pulse_i)) == '0));
endmodule

// File: rtl/stb_compose.sv
// Module: service request enable register and status byte assembly.
// Builds the status byte from the summary inputs and derives the master
// summary from the enabled bits, ignoring the enable at the summary position.
// Assumes device clear has priority over an enable write.
module stb_compose
    import stat_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dev_clr_i,
    input  logic         sre_wr_i,
    input  logic [W-1:0] sre_wdata_i,
    input  logic         oper_sum_i,
    input  logic         esb_i,
    input  logic         mav_i,
    input  logic         ques_sum_i,
    output logic [W-1:0] stb_o,
    output logic         mss_o
);
    localparam logic [W-1:0] MSS_MASK = W'(1) << MSS_BIT;

    logic [W-1:0] sre_q;
    logic [W-1:0] base;

    // Enable register: cleared by power-on or device clear, else loaded on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sre_q <= '0;
        end else if (dev_clr_i) begin
            sre_q <= '0;
        end else if (sre_wr_i) begin
            sre_q <= sre_wdata_i;
        end
    end

    // Status byte without the summary bit, then master summary over the rest.
    always_comb begin
        base           = '0;
        base[OPER_BIT] = oper_sum_i;
        base[ESB_BIT]  = esb_i;
        base[MAV_BIT]  = mav_i;
        base[QUES_BIT] = ques_sum_i;
        mss_o          = |(base & sre_q & ~MSS_MASK);
        stb_o          = base;
        stb_o[MSS_BIT] = mss_o;
    end

    // R7
    dev_clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_clr_i |=> !mss_o);

    // R7
    sre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_clr_i && !sre_wr_i) |=> $stable(sre_q));
endmodule

// File: rtl/srq_gen.sv
// Module: service request flag.
// Raises the request on a rising master summary, drops it when the summary
// goes away, and withdraws it on a serial poll until a new rise occurs.
// Assumes poll_i is a single-cycle strobe.
module srq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic mss_i,
    input  logic poll_i,
    output logic rqs_o
);
    logic mss_q;
    logic rqs_q;
    logic rise;

    // Edge detect of the master summary.
    always_comb begin
        rise = mss_i & ~mss_q;
    end

    // Summary history and request flag; a new rise beats a poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mss_q <= 1'b0;
            rqs_q <= 1'b0;
        end else begin
            mss_q <= mss_i;
            if (!mss_i)      rqs_q <= 1'b0;
            else if (rise)   rqs_q <= 1'b1;
            else if (poll_i) rqs_q <= 1'b0;
        end
    end

    assign rqs_o = rqs_q;

    // R8
    rqs_needs_mss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rqs_q |-> $past(mss_i));

    // R9
    poll_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !rise) |=> !rqs_q);

    // R8
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> rqs_q);
endmodule

// File: rtl/status_report_unit.sv
// Module: top of the instrument status reporting unit.
// Connects the event register, status byte assembly and service request flag.
// Assumes all strobes are synchronous single-cycle pulses and rst_n is the
// power-on reset.
module status_report_unit
    import stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dev_clr_i,
    input  logic             cls_i,
    input  logic [REG_W-1:0] evt_pulse_i,
    input  logic             oq_nonempty_i,
    input  logic             ques_sum_i,
    input  logic             oper_sum_i,
    input  logic             sre_wr_i,
    input  logic [REG_W-1:0] sre_wdata_i,
    input  logic             ese_wr_i,
    input  logic [REG_W-1:0] ese_wdata_i,
    input  logic             esr_rd_i,
    output logic [REG_W-1:0] esr_o,
    output logic [REG_W-1:0] stb_o,
    input  logic             poll_i,
    output logic [REG_W-1:0] poll_byte_o,
    output logic             srq_o
);
    logic esb;
    logic mss;
    logic clr_evt;

    // Either clear source empties the event register.
    always_comb begin
        clr_evt = esr_rd_i | cls_i;
    end

    evt_latch #(.W(REG_W)) u_evt (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_pulse_i  (evt_pulse_i),
        .clr_i        (clr_evt),
        .mask_wr_i    (ese_wr_i),
        .mask_wdata_i (ese_wdata_i),
        .esr_o        (esr_o),
        .sum_o        (esb)
    );

    stb_compose #(.W(REG_W)) u_stb (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_clr_i   (dev_clr_i),
        .sre_wr_i    (sre_wr_i),
        .sre_wdata_i (sre_wdata_i),
        .oper_sum_i  (oper_sum_i),
        .esb_i       (esb),
        .mav_i       (oq_nonempty_i),
        .ques_sum_i  (ques_sum_i),
        .stb_o       (stb_o),
        .mss_o       (mss)
    );

    srq_gen u_srq (
        .clk    (clk),
        .rst_n  (rst_n),
        .mss_i  (mss),
        .poll_i (poll_i),
        .rqs_o  (srq_o)
    );

    // Serial-poll byte: request flag in place of the master summary.
    always_comb begin
        poll_byte_o          = stb_o;
        poll_byte_o[MSS_BIT] = srq_o;
    end

    // R6
    mss_in_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o[MSS_BIT] == mss);
endmodule

// File: tb/sim_status_report_unit.sv
module sim_status_report_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_clr_i = 1'b0;
    logic       cls_i = 1'b0;
    logic [7:0] evt_pulse_i = '0;
    logic       oq_nonempty_i = 1'b0;
    logic       ques_sum_i = 1'b0;
    logic       oper_sum_i = 1'b0;
    logic       sre_wr_i = 1'b0;
    logic [7:0] sre_wdata_i = '0;
    logic       ese_wr_i = 1'b0;
    logic [7:0] ese_wdata_i = '0;
    logic       esr_rd_i = 1'b0;
    logic       poll_i = 1'b0;
    logic [7:0] esr_o;
    logic [7:0] stb_o;
    logic [7:0] poll_byte_o;
    logic       srq_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    status_report_unit u0 (
        .clk(clk), .rst_n(rst_n), .dev_clr_i(dev_clr_i), .cls_i(cls_i),
        .evt_pulse_i(evt_pulse_i), .oq_nonempty_i(oq_nonempty_i),
        .ques_sum_i(ques_sum_i), .oper_sum_i(oper_sum_i),
        .sre_wr_i(sre_wr_i), .sre_wdata_i(sre_wdata_i),
        .ese_wr_i(ese_wr_i), .ese_wdata_i(ese_wdata_i),
        .esr_rd_i(esr_rd_i), .esr_o(esr_o), .stb_o(stb_o),
        .poll_i(poll_i), .poll_byte_o(poll_byte_o), .srq_o(srq_o)
    );

    // Advance one clock; inputs change and outputs are sampled mid-period.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic write_sre(input logic [7:0] v);
        sre_wr_i = 1'b1; sre_wdata_i = v; step(); sre_wr_i = 1'b0;
    endtask

    task automatic write_ese(input logic [7:0] v);
        ese_wr_i = 1'b1; ese_wdata_i = v; step(); ese_wr_i = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] v);
        evt_pulse_i = v; step(); evt_pulse_i = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1; #1;
        chk("R1 esr", esr_o, 8'h80);
        chk("R1 stb", stb_o, 8'h00);
        chk("R1 srq", {7'd0, srq_o}, 8'h00);
        esr_rd_i = 1'b1; step(); esr_rd_i = 1'b0;
        chk("R3 read clears", esr_o, 8'h00);
    endtask

    task automatic t_events();
        pulse(8'h05);
        chk("R2 first", esr_o, 8'h05);
        pulse(8'h10);
        chk("R2 merge", esr_o, 8'h15);
        step(); step();
        chk("R2 sticky", esr_o, 8'h15);
    endtask

    task automatic t_clear();
        esr_rd_i = 1'b1; evt_pulse_i = 8'h02; step();
        esr_rd_i = 1'b0; evt_pulse_i = '0;
        chk("R3 event beats read", esr_o, 8'h02);
        cls_i = 1'b1; step(); cls_i = 1'b0;
        chk("R3 cls clears", esr_o, 8'h00);
    endtask

    task automatic t_esb();
        write_ese(8'h22);
        chk("R4 no events", stb_o, 8'h00);
        pulse(8'h01);
        chk("R4 masked event", stb_o, 8'h00);
        pulse(8'h20);
        chk("R4 enabled event", stb_o, 8'h20);
        cls_i = 1'b1; step(); cls_i = 1'b0;
        chk("R4 after cls", stb_o, 8'h00);
        pulse(8'h02);
        chk("R4 mask kept by cls", stb_o, 8'h20);
        esr_rd_i = 1'b1; step(); esr_rd_i = 1'b0;
    endtask

    task automatic t_stb_bits();
        oper_sum_i = 1'b1; #1;
        chk("R5 oper", stb_o, 8'h80);
        ques_sum_i = 1'b1; #1;
        chk("R5 ques", stb_o, 8'h88);
        oq_nonempty_i = 1'b1; #1;
        chk("R5 mav", stb_o, 8'h98);
        oper_sum_i = 1'b0; ques_sum_i = 1'b0; oq_nonempty_i = 1'b0; #1;
        chk("R5 idle", stb_o, 8'h00);
    endtask

    task automatic t_mss();
        write_sre(8'h40);
        oper_sum_i = 1'b1; ques_sum_i = 1'b1; oq_nonempty_i = 1'b1;
        step(); step();
        chk("R6 bit6 enable ignored", stb_o, 8'h98);
        chk("R8 no request", {7'd0, srq_o}, 8'h00);
        oper_sum_i = 1'b0; ques_sum_i = 1'b0;
        write_sre(8'h10);
        chk("R6 mav enabled", stb_o, 8'h50);
        chk("R8 not yet", {7'd0, srq_o}, 8'h00);
        step();
        chk("R8 request up", {7'd0, srq_o}, 8'h01);
        write_sre(8'h08);
        chk("R6 other bit enabled", stb_o, 8'h10);
        step();
        chk("R8 request down", {7'd0, srq_o}, 8'h00);
    endtask

    task automatic t_sre();
        write_sre(8'h10);
        step();
        cls_i = 1'b1; step(); cls_i = 1'b0;
        chk("R7 cls keeps enable", stb_o, 8'h50);
        dev_clr_i = 1'b1; sre_wr_i = 1'b1; sre_wdata_i = 8'hFF; step();
        dev_clr_i = 1'b0; sre_wr_i = 1'b0;
        chk("R7 dev clear wins", stb_o, 8'h10);
        step();
        chk("R8 down after dev clear", {7'd0, srq_o}, 8'h00);
    endtask

    task automatic t_poll();
        write_sre(8'h10);
        step();
        chk("R9 poll byte", poll_byte_o, 8'h50);
        poll_i = 1'b1; step(); poll_i = 1'b0;
        chk("R9 cleared by poll", {7'd0, srq_o}, 8'h00);
        chk("R9 poll byte after", poll_byte_o, 8'h10);
        chk("R9 stb keeps mss", stb_o, 8'h50);
        step(); step();
        chk("R9 stays low", {7'd0, srq_o}, 8'h00);
        oq_nonempty_i = 1'b0; step();
        oq_nonempty_i = 1'b1; step();
        chk("R9 rearmed", {7'd0, srq_o}, 8'h01);
        oq_nonempty_i = 1'b0; step();
        oq_nonempty_i = 1'b1; poll_i = 1'b1; step(); poll_i = 1'b0;
        chk("R9 rise beats poll", {7'd0, srq_o}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_events();
        t_clear();
        t_esb();
        t_stb_bits();
        t_mss();
        t_sre();
        t_poll();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule